// File: doc/BRIEF.md
# SPI Master with Chip-Select Hold

This block is a mode-0 SPI master that moves one word per request. A word is 1 to 16 bits long. Each request carries its write data, its length and a hold flag. The hold flag decides whether chip select stays low after the word's last bit. With the flag set, several requests join into one long frame, so a frame can be longer than the word limit. A 40-bit memory access, for example, is sent as 16 + 16 + 8 bits with the hold flag on the first two words.

The master never reads on its own. On every rising SCLK edge of every word it shifts one MISO bit into the receive register. To read N bits, the caller transmits N bits, using dummy data where needed. When the word ends, the received bits appear right-justified on `rx_data` together with a one-cycle `rx_valid` pulse. SCLK runs only while a word is being shifted. It stays low between requests, even while chip select is held.

The control is a state machine with these states:
- **IDLE**: chip select is high.
- **LOW**: SCLK is low for half a period, with MOSI already set up.
- **HIGH**: SCLK is high for half a period.
- **TRAIL**: chip select stays low for half a period after the final SCLK edge.
- **HOLD**: chip select is low and no clock runs.
- **GAP_A** and **GAP_B**: chip select is high, for half a period each.

The transitions are:
- IDLE→LOW and HOLD→LOW when a request is accepted.
- LOW→HIGH on a half-period tick, where MISO is sampled.
- HIGH→LOW on a tick when bits remain, where MOSI shifts.
- HIGH→HOLD on a tick at the last bit when the hold flag is set.
- HIGH→TRAIL on a tick at the last bit when the hold flag is clear.
- TRAIL→GAP_A, GAP_A→GAP_B and GAP_B→IDLE, each on a tick.

Top module: `spi_hold_master`

## Requirements
- R1: After reset, `cs_n` is 1, `sclk` is 0, `busy` is 0 and `rx_valid` is 0.
- R2: A request is accepted when `req_valid` is 1 while `busy` is 0. `busy` is 1 in the next cycle. A request presented while `busy` is 1 is ignored and produces no word.
- R3: A word shifts exactly `req_len_m1`+1 bits. This means exactly that many SCLK rising edges, from 1 (`req_len_m1`=0) up to 16 (`req_len_m1`=15).
- R4: MOSI sends bit `req_len_m1` of `req_data` first and bit 0 last. MOSI changes only while SCLK is low, and is stable during every SCLK high phase.
- R5: On each SCLK rising edge, MISO is shifted into the receive register. When the word ends, `rx_data` holds the received bits right-justified: the first bit is at bit `req_len_m1` and all higher bits are 0. `rx_valid` pulses for exactly one cycle.
- R6: SCLK idles low. Each half period lasts `clk_div`+1 system clock cycles, so consecutive rising edges within a word are 2*(`clk_div`+1) cycles apart.
- R7: For a word with hold 0, `cs_n` rises exactly `clk_div`+1 cycles after the final falling SCLK edge. It then stays high for at least 2*(`clk_div`+1) cycles before the next frame. `busy` stays 1 until that gap has elapsed.
- R8: For a word with hold 1, `cs_n` stays 0 after the word and `busy` drops to 0. The next request continues the same frame, and `cs_n` does not rise until a word with hold 0 ends.
- R9: SCLK is 0 whenever `busy` is 0 or `cs_n` is 1. No clocks are produced between requests.
- R10: `clk_div` is captured when a request is accepted. Changing it while a word is in flight does not alter that word's timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| clk_div | input | 8 | Half-period divider; each half period lasts this value plus one clock cycles |
| req_valid | input | 1 | Request strobe |
| req_data | input | 16 | Write data, right-justified |
| req_len_m1 | input | 4 | Word length minus one |
| req_hold | input | 1 | Keep chip select low after this word |
| busy | output | 1 | Word in progress; requests are refused |
| rx_data | output | 16 | Received bits, right-justified |
| rx_valid | output | 1 | One-cycle pulse when `rx_data` is updated |
| sclk | output | 1 | Serial clock, idle low |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| cs_n | output | 1 | Active-low chip select |

## Verification
The hardest situation to reach from the ports is a multi-word held frame whose gaps between words are long and uneven. That is the only place where chip select must stay low while SCLK must stay silent. It is also where a spurious clock edge or a chip-select glitch would go unnoticed by a per-word check. The stimulus builds a 40-bit frame from 16, 16 and 8-bit words and idles for many cycles in HOLD between them. A slave model in the bench counts every SCLK edge and every chip-select transition across the whole frame, so any extra edge shows up in the next word's bit count or in the frame count. Each request also rewrites `clk_div` immediately after acceptance, and attempts to issue requests while `busy` is high, to show that in-flight words keep their captured timing.

// File: rtl/spi_hold_pkg.sv
package spi_hold_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LOW,
        ST_HIGH,
        ST_TRAIL,
        ST_HOLD,
        ST_GAP_A,
        ST_GAP_B
    } spi_state_t;

endpackage

// File: rtl/spi_half_timer.sv
module spi_half_timer #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [DIV_W-1:0] div_val,
    output logic             tick
);

    logic [DIV_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (!run || cnt_q == div_val) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + DIV_W'(1);
        end
    end

    assign tick = run && (cnt_q == div_val);

endmodule

// File: rtl/spi_tx_shift.sv
module spi_tx_shift #(
    parameter int WORD_W = 16,
    parameter int LEN_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              shift,
    input  logic [WORD_W-1:0] data,
    input  logic [LEN_W-1:0]  len_m1,
    output logic              msb
);

    localparam logic [LEN_W-1:0] TOP_IDX = LEN_W'(WORD_W - 1);

    logic [WORD_W-1:0] sh_q;

    // Left-align the word so the first bit to send sits in the top position.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh_q <= '0;
        end else if (load) begin
            sh_q <= data << (TOP_IDX - len_m1);
        end else if (shift) begin
            sh_q <= {sh_q[WORD_W-2:0], 1'b0};
        end
    end

    assign msb = sh_q[WORD_W-1];

endmodule

// File: rtl/spi_rx_shift.sv
module spi_rx_shift #(
    parameter int WORD_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              sample,
    input  logic              bit_in,
    output logic [WORD_W-1:0] word
);

    logic [WORD_W-1:0] sh_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh_q <= '0;
        end else if (clear) begin
            sh_q <= '0;
        end else if (sample) begin
            sh_q <= {sh_q[WORD_W-2:0], bit_in};
        end
    end

    assign word = sh_q;

endmodule

// File: rtl/spi_hold_master.sv
module spi_hold_master
    import spi_hold_pkg::*;
#(
    parameter  int WORD_W = 16,
    parameter  int DIV_W  = 8,
    localparam int LEN_W  = $clog2(WORD_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DIV_W-1:0]  clk_div,
    input  logic              req_valid,
    input  logic [WORD_W-1:0] req_data,
    input  logic [LEN_W-1:0]  req_len_m1,
    input  logic              req_hold,
    output logic              busy,
    output logic [WORD_W-1:0] rx_data,
    output logic              rx_valid,
    output logic              sclk,
    output logic              mosi,
    input  logic              miso,
    output logic              cs_n
);

    spi_state_t        state_q, state_d;
    logic [LEN_W-1:0]  bits_left_q;
    logic              hold_q;
    logic [DIV_W-1:0]  div_q;
    logic              tick;
    logic              run;
    logic              accept;
    logic              last_bit;
    logic              sample_en;
    logic              shift_en;
    logic              done;
    logic              tx_msb;
    logic [WORD_W-1:0] rx_word;
    logic [WORD_W-1:0] rx_data_q;
    logic              rx_valid_q;

    // Control strobes
    assign accept    = req_valid && (state_q == ST_IDLE || state_q == ST_HOLD);
    assign last_bit  = (bits_left_q == '0);
    assign run       = (state_q == ST_LOW)    || (state_q == ST_HIGH)  ||
                       (state_q == ST_TRAIL)  || (state_q == ST_GAP_A) ||
                       (state_q == ST_GAP_B);
    assign sample_en = (state_q == ST_LOW)  && tick;
    assign shift_en  = (state_q == ST_HIGH) && tick && !last_bit;
    assign done      = (state_q == ST_HIGH) && tick && last_bit;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (accept) state_d = ST_LOW;
            ST_LOW:   if (tick)   state_d = ST_HIGH;
            ST_HIGH: begin
                if (tick) begin
                    if (!last_bit)   state_d = ST_LOW;
                    else if (hold_q) state_d = ST_HOLD;
                    else             state_d = ST_TRAIL;
                end
            end
            ST_TRAIL: if (tick)   state_d = ST_GAP_A;
            ST_HOLD:  if (accept) state_d = ST_LOW;
            ST_GAP_A: if (tick)   state_d = ST_GAP_B;
            ST_GAP_B: if (tick)   state_d = ST_IDLE;
            default:              state_d = ST_IDLE;
        endcase
    end

    // Outputs decoded from the state
    always_comb begin
        sclk = (state_q == ST_HIGH);
        cs_n = (state_q == ST_IDLE) || (state_q == ST_GAP_A) || (state_q == ST_GAP_B);
        busy = !((state_q == ST_IDLE) || (state_q == ST_HOLD));
        mosi = cs_n ? 1'b0 : tx_msb;
    end

    // Per-word context captured at acceptance
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bits_left_q <= '0;
            hold_q      <= 1'b0;
            div_q       <= '0;
        end else if (accept) begin
            bits_left_q <= req_len_m1;
            hold_q      <= req_hold;
            div_q       <= clk_div;
        end else if (shift_en) begin
            bits_left_q <= bits_left_q - LEN_W'(1);
        end
    end

    // Receive result register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rx_data_q  <= '0;
            rx_valid_q <= 1'b0;
        end else begin
            rx_valid_q <= done;
            if (done) begin
                rx_data_q <= rx_word;
            end
        end
    end

    assign rx_data  = rx_data_q;
    assign rx_valid = rx_valid_q;

    spi_half_timer #(.DIV_W(DIV_W)) timer_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (run),
        .div_val (div_q),
        .tick    (tick)
    );

    spi_tx_shift #(.WORD_W(WORD_W), .LEN_W(LEN_W)) tx_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .load   (accept),
        .shift  (shift_en),
        .data   (req_data),
        .len_m1 (req_len_m1),
        .msb    (tx_msb)
    );

    spi_rx_shift #(.WORD_W(WORD_W)) rx_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .clear  (accept),
        .sample (sample_en),
        .bit_in (miso),
        .word   (rx_word)
    );

endmodule

// File: rtl/spi_hold_master_chk.sv
module spi_hold_master_chk (
    input logic clk,
    input logic rst_n,
    input logic req_valid,
    input logic busy,
    input logic sclk,
    input logic cs_n,
    input logic mosi,
    input logic rx_valid
);

    // R2: an accepted request makes the block busy in the next cycle
    p_accept_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !busy) |=> busy);

    // R4: MOSI does not move during an SCLK high phase
    p_mosi_stable_r4: assert property (@(posedge clk) disable iff (!rst_n)
        sclk |-> $stable(mosi));

    // R5: the result strobe lasts a single cycle
    p_rx_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |=> !rx_valid);

    // R7: chip select is released while the block still reports busy
    p_release_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cs_n) |-> busy);

    // R8: a word finishing with busy low leaves chip select asserted
    p_hold_cs_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && !busy) |-> !cs_n);

    // R9: no serial clock while idle or holding
    p_idle_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !sclk);

    // R9: no serial clock with chip select released
    p_cs_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |-> !sclk);

endmodule

bind spi_hold_master spi_hold_master_chk chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .busy      (busy),
    .sclk      (sclk),
    .cs_n      (cs_n),
    .mosi      (mosi),
    .rx_valid  (rx_valid)
);

// File: tb/spi_hold_master_tb_top.sv
module spi_hold_master_tb_top;

    typedef struct packed {
        logic [15:0] data;
        logic [4:0]  nbits;
        logic        hold;
        logic [7:0]  div;
    } item_t;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [7:0]  clk_div;
    logic        req_valid;
    logic [15:0] req_data;
    logic [3:0]  req_len_m1;
    logic        req_hold;
    logic        busy;
    logic [15:0] rx_data;
    logic        rx_valid;
    logic        sclk;
    logic        mosi;
    logic        miso;
    logic        cs_n;

    always #10 clk = ~clk;

    spi_hold_master dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .clk_div    (clk_div),
        .req_valid  (req_valid),
        .req_data   (req_data),
        .req_len_m1 (req_len_m1),
        .req_hold   (req_hold),
        .busy       (busy),
        .rx_data    (rx_data),
        .rx_valid   (rx_valid),
        .sclk       (sclk),
        .mosi       (mosi),
        .miso       (miso),
        .cs_n       (cs_n)
    );

    int    n_checks = 0;
    int    n_fail   = 0;
    int    cyc      = 0;
    int    frames   = 0;
    bit    finished = 0;
    item_t sb_q[$];

    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Slave model: MISO comes from an LFSR stepped on each falling SCLK edge
    logic [15:0] lfsr = 16'hACE1;
    assign miso = lfsr[0];

    // Monitor / scoreboard side
    logic [15:0] mosi_acc = '0;
    logic [15:0] miso_acc = '0;
    int  bit_cnt = 0, last_rise = 0, last_fall = 0, cs_rise_cyc = 0;
    int  last_div = 0, gap_div = 0, cs_rises = 0, cs_falls = 0;
    bit  seen_rise = 0, prev_sclk = 0, prev_cs = 1, prev_rxv = 0;

    always @(negedge clk) begin
        if (rst_n) begin
            if (!busy && sclk) check(0, "R9 sclk while not busy", 32'(sclk), 32'h0);
            if (rx_valid && prev_rxv) check(0, "R5 rx_valid longer than one cycle", 32'h1, 32'h0);
            if (sclk && !prev_sclk) begin
                if (cs_n) check(0, "R9 sclk with cs_n high", 32'h1, 32'h0);
                if (bit_cnt > 0 && sb_q.size() > 0)
                    check(cyc - last_rise == 2 * (int'(sb_q[0].div) + 1), "R6/R10 sclk period",
                          32'(cyc - last_rise), 32'(2 * (int'(sb_q[0].div) + 1)));
                mosi_acc <= {mosi_acc[14:0], mosi};
                miso_acc <= {miso_acc[14:0], miso};
                bit_cnt  <= bit_cnt + 1;
                last_rise = cyc;
            end
            if (!sclk && prev_sclk) begin
                lfsr <= {lfsr[0] ^ lfsr[2] ^ lfsr[3] ^ lfsr[5], lfsr[15:1]};
                last_fall = cyc;
            end
            if (cs_n && !prev_cs) begin
                check(cyc - last_fall == last_div + 1, "R7 cs_n release delay",
                      32'(cyc - last_fall), 32'(last_div + 1));
                cs_rise_cyc = cyc;
                gap_div     = last_div;
                seen_rise   = 1;
                cs_rises++;
            end
            if (!cs_n && prev_cs) begin
                if (seen_rise)
                    check(cyc - cs_rise_cyc >= 2 * (gap_div + 1), "R7 cs_n high gap",
                          32'(cyc - cs_rise_cyc), 32'(2 * (gap_div + 1)));
                cs_falls++;
            end
            if (rx_valid) begin
                if (sb_q.size() == 0) begin
                    check(0, "R2 unexpected word", 32'(rx_data), 32'h0);
                end else begin
                    item_t it;
                    logic [15:0] mask;
                    it   = sb_q.pop_front();
                    mask = 16'((17'h1 << it.nbits) - 17'h1);
                    check(bit_cnt == int'(it.nbits), "R3 bit count", 32'(bit_cnt), 32'(it.nbits));
                    check((mosi_acc & mask) == (it.data & mask), "R4 mosi bits",
                          32'(mosi_acc & mask), 32'(it.data & mask));
                    check(rx_data == miso_acc, "R5 rx_data", 32'(rx_data), 32'(miso_acc));
                    if (it.hold) check(!busy && !cs_n, "R8 held word leaves cs_n low, not busy",
                                       32'({busy, cs_n}), 32'h0);
                    else         check(busy, "R7 busy through release", 32'(busy), 32'h1);
                    last_div = int'(it.div);
                end
                mosi_acc <= '0;
                miso_acc <= '0;
                bit_cnt  <= 0;
            end
            prev_sclk = sclk;
            prev_cs   = cs_n;
            prev_rxv  = rx_valid;
        end
    end

    // Driver
    task automatic send(input logic [15:0] data, input logic [3:0] len_m1, input logic hold,
                        input logic [7:0] div, input bit poke);
        item_t it;
        @(negedge clk);
        while (busy) @(negedge clk);
        clk_div    = div;
        req_valid  = 1'b1;
        req_data   = data;
        req_len_m1 = len_m1;
        req_hold   = hold;
        it.data  = data;
        it.nbits = 5'(len_m1) + 5'd1;
        it.hold  = hold;
        it.div   = div;
        sb_q.push_back(it);
        if (!hold) frames++;
        @(negedge clk);
        req_valid = 1'b0;
        clk_div   = ~div;   // R10: must not affect the word in flight
        check(busy, "R2 busy after accept", 32'(busy), 32'h1);
        if (poke) begin
            for (int i = 0; i < 4; i++) begin
                req_valid  = busy;
                req_data   = 16'hDEAD;
                req_len_m1 = 4'd3;
                @(negedge clk);
            end
            req_valid = 1'b0;
        end
    endtask

    task automatic drain();
        @(negedge clk);
        while (busy || sb_q.size() != 0) @(negedge clk);
    endtask

    initial begin
        rst_n = 1'b0; clk_div = 8'd0; req_valid = 1'b0;
        req_data = '0; req_len_m1 = '0; req_hold = 1'b0;
        repeat (4) @(negedge clk);
        check(cs_n == 1'b1, "R1 reset cs_n", 32'(cs_n), 32'h1);
        check(sclk == 1'b0, "R1 reset sclk", 32'(sclk), 32'h0);
        check(busy == 1'b0, "R1 reset busy", 32'(busy), 32'h0);
        check(rx_valid == 1'b0, "R1 reset rx_valid", 32'(rx_valid), 32'h0);
        rst_n = 1'b1;

        send(16'h00A5, 4'd7, 1'b0, 8'd1, 0);      // R3 R4 R5 plain byte
        send(16'h0001, 4'd0, 1'b0, 8'd0, 0);      // R3 single bit
        send(16'hBEEF, 4'd15, 1'b0, 8'd2, 0);     // R3 full 16 bits
        drain();

        // R8: 40-bit frame from three words, idling in HOLD between them
        send(16'h1234, 4'd15, 1'b1, 8'd0, 0);
        drain();
        for (int i = 0; i < 12; i++) begin
            @(negedge clk);
            check(!cs_n && !sclk, "R8/R9 held idle", 32'({cs_n, sclk}), 32'h0);
        end
        send(16'h5678, 4'd15, 1'b1, 8'd0, 0);
        drain();
        repeat (20) @(negedge clk);
        check(!cs_n, "R8 cs_n still held", 32'(cs_n), 32'h0);
        send(16'h009A, 4'd7, 1'b0, 8'd0, 0);
        drain();

        // R2: requests while busy are dropped
        send(16'h0ABC, 4'd11, 1'b0, 8'd3, 1);
        drain();
        // R7: frames back to back with mixed dividers
        send(16'h0F0F, 4'd9, 1'b0, 8'd0, 0);
        send(16'h7001, 4'd14, 1'b1, 8'd1, 1);
        send(16'h0003, 4'd1, 1'b0, 8'd1, 0);
        drain();
        repeat (10) @(negedge clk);

        check(sb_q.size() == 0, "R2 all words completed", 32'(sb_q.size()), 32'h0);
        check(cs_falls == frames, "R8 cs_n frame starts", 32'(cs_falls), 32'(frames));
        check(cs_rises == frames, "R8 cs_n frame ends", 32'(cs_rises), 32'(frames));
        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog expired actual=%0d expected=done", cyc);
            $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
            $finish;
        end
    end

endmodule